// File: doc/BRIEF.md
# Register Rename Map with Free List

This block translates architectural (logical) register numbers into physical register numbers for an out-of-order core in which every value lives in a physical register file larger than the logical one. It holds a speculative map from each logical register to its current physical register, a committed copy of that map, and a first-in first-out queue of physical registers that nothing references. When an instruction issues, its destination gets the physical register at the head of the queue. The block reports that new register together with the one it replaces, and translates the two source operands through the speculative map.

When an instruction commits, the scheduler hands back the new and previous physical registers that were reported at issue. The committed map takes the new register, and the previous one goes to the tail of the free queue. On a misprediction flush, the speculative map is overwritten with the committed map. In the same cycle the free queue is rebuilt from the committed map, so every register allocated after the last commit becomes free again. Data storage, scheduling and the ordering of commits lie outside this block.

Top module: `reg_rename`

## Requirements
- R1: After reset, logical register l maps to physical register l (source lookups return l), issue is ready, and the first register offered is NUM_LOG (8 with defaults); the free queue then holds NUM_LOG..NUM_PHYS-1 in ascending order.
- R2: In a cycle with iss_valid and iss_ready high, iss_new_preg is the head of the free queue and iss_old_preg is the current speculative mapping of iss_dst. From the next cycle, lookups of iss_dst return iss_new_preg.
- R3: Successive issues receive the free registers in first-in first-out order.
- R4: A source lookup that names the destination issued in the same cycle returns the mapping from before that issue.
- R5: A commit appends cmt_old_preg to the tail of the free queue, so it is handed out only after every register already queued.
- R6: When the free queue is empty, iss_ready is low, and an issue request changes neither the map nor the queue.
- R7: In a cycle with flush high, iss_ready is low and no issue takes effect. From the next cycle, every lookup returns the committed mapping.
- R8: After a flush, the free queue holds exactly the NUM_PHYS-NUM_LOG registers absent from the committed map, in ascending order.
- R9: A commit (cmt_dst mapped to cmt_new_preg in the committed map) leaves the speculative map unchanged.
- R10: A commit and a flush in the same cycle apply the commit before the restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request for one instruction |
| iss_dst | input | clog2(NUM_LOG) | Destination logical register |
| iss_src_a | input | clog2(NUM_LOG) | First source logical register |
| iss_src_b | input | clog2(NUM_LOG) | Second source logical register |
| iss_ready | output | 1 | Issue accepted this cycle if requested |
| iss_new_preg | output | clog2(NUM_PHYS) | Physical register allocated to the destination |
| iss_old_preg | output | clog2(NUM_PHYS) | Physical register the destination mapped to before |
| src_a_preg | output | clog2(NUM_PHYS) | Translation of iss_src_a |
| src_b_preg | output | clog2(NUM_PHYS) | Translation of iss_src_b |
| cmt_valid | input | 1 | An instruction with a destination commits |
| cmt_dst | input | clog2(NUM_LOG) | Committed destination logical register |
| cmt_new_preg | input | clog2(NUM_PHYS) | Register allocated to it at issue |
| cmt_old_preg | input | clog2(NUM_PHYS) | Register it superseded, to be freed |
| flush | input | 1 | Misprediction: restore the committed state |

## Verification
Translations, iss_ready and the new and old registers are combinational, so they are due in the same cycle as the request. The bench samples them shortly after driving inputs on the falling edge, before the next rising edge. Issues, commits and flushes change the map and queue at the rising edge, so their effects are due one cycle later. The bench updates its arithmetic model just after that edge and compares on the following step. Near-exhaustive sweeps of all eight lookups, a full drain of the queue and a long pseudo-random mix keep every comparison aligned to those two latencies.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int unsigned LOG_REGS_DEF  = 8;
    localparam int unsigned PHYS_REGS_DEF = 24;

    function automatic int unsigned idx_bits(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table
    import rename_pkg::*;
#(
    parameter int unsigned NL = LOG_REGS_DEF,
    parameter int unsigned NP = PHYS_REGS_DEF,
    localparam int unsigned LW = idx_bits(NL),
    localparam int unsigned PW = idx_bits(NP)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iss_fire,
    input  logic [LW-1:0]          iss_dst,
    input  logic [PW-1:0]          iss_new,
    input  logic [LW-1:0]          look_a,
    input  logic [LW-1:0]          look_b,
    input  logic                   cmt_valid,
    input  logic [LW-1:0]          cmt_dst,
    input  logic [PW-1:0]          cmt_new,
    input  logic                   flush,
    output logic [PW-1:0]          dst_prev,
    output logic [PW-1:0]          look_a_preg,
    output logic [PW-1:0]          look_b_preg,
    output logic [NL-1:0][PW-1:0]  spec_map_o,
    output logic [NL-1:0][PW-1:0]  cmt_map_o,
    output logic [NL-1:0][PW-1:0]  cmt_map_next_o
);
    typedef struct packed {
        logic [NL-1:0][PW-1:0] spec;
        logic [NL-1:0][PW-1:0] arch;
    } map_state_t;

    map_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // commit is older than any flush in the same cycle
        if (cmt_valid) begin
            st_d.arch[cmt_dst] = cmt_new;
        end
        if (flush) begin
            st_d.spec = st_d.arch;
        end else if (iss_fire) begin
            st_d.spec[iss_dst] = iss_new;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < int'(NL); l++) begin
                st_q.spec[l] <= PW'(l);
                st_q.arch[l] <= PW'(l);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign dst_prev       = st_q.spec[iss_dst];
    assign look_a_preg    = st_q.spec[look_a];
    assign look_b_preg    = st_q.spec[look_b];
    assign spec_map_o     = st_q.spec;
    assign cmt_map_o      = st_q.arch;
    assign cmt_map_next_o = st_d.arch;
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list
    import rename_pkg::*;
#(
    parameter int unsigned NL = LOG_REGS_DEF,
    parameter int unsigned NP = PHYS_REGS_DEF,
    localparam int unsigned PW    = idx_bits(NP),
    localparam int unsigned DEPTH = NP - NL,
    localparam int unsigned AW    = idx_bits(DEPTH),
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pop,
    input  logic                   push,
    input  logic [PW-1:0]          push_preg,
    input  logic                   rebuild,
    input  logic [NL-1:0][PW-1:0]  rebuild_map,
    output logic [PW-1:0]          head_preg,
    output logic                   empty,
    output logic [CW-1:0]          count
);
    typedef struct packed {
        logic [DEPTH-1:0][PW-1:0] slots;
        logic [AW-1:0]            head;
        logic [AW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } fl_state_t;

    fl_state_t    fl_d, fl_q;
    logic [NP-1:0] in_use;
    int            fill;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        fl_d   = fl_q;
        in_use = '0;
        fill   = 0;
        if (rebuild) begin
            for (int l = 0; l < int'(NL); l++) begin
                in_use[rebuild_map[l]] = 1'b1;
            end
            for (int p = 0; p < int'(NP); p++) begin
                if (!in_use[p]) begin
                    if (fill < int'(DEPTH)) begin
                        fl_d.slots[AW'(fill)] = PW'(p);
                    end
                    fill = fill + 1;
                end
            end
            fl_d.head = '0;
            fl_d.tail = '0;
            fl_d.cnt  = CW'(DEPTH);
        end else begin
            if (push) begin
                fl_d.slots[fl_q.tail] = push_preg;
                fl_d.tail             = wrap_inc(fl_q.tail);
            end
            if (pop) begin
                fl_d.head = wrap_inc(fl_q.head);
            end
            fl_d.cnt = fl_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                fl_q.slots[i] <= PW'(NL + i);
            end
            fl_q.head <= '0;
            fl_q.tail <= '0;
            fl_q.cnt  <= CW'(DEPTH);
        end else begin
            fl_q <= fl_d;
        end
    end

    assign head_preg = fl_q.slots[fl_q.head];
    assign empty     = (fl_q.cnt == '0);
    assign count     = fl_q.cnt;
endmodule

// File: rtl/reg_rename.sv
module reg_rename
    import rename_pkg::*;
#(
    parameter int unsigned NL = LOG_REGS_DEF,
    parameter int unsigned NP = PHYS_REGS_DEF,
    localparam int unsigned LW = idx_bits(NL),
    localparam int unsigned PW = idx_bits(NP),
    localparam int unsigned CW = $clog2(NP - NL + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [LW-1:0] iss_dst,
    input  logic [LW-1:0] iss_src_a,
    input  logic [LW-1:0] iss_src_b,
    output logic          iss_ready,
    output logic [PW-1:0] iss_new_preg,
    output logic [PW-1:0] iss_old_preg,
    output logic [PW-1:0] src_a_preg,
    output logic [PW-1:0] src_b_preg,
    input  logic          cmt_valid,
    input  logic [LW-1:0] cmt_dst,
    input  logic [PW-1:0] cmt_new_preg,
    input  logic [PW-1:0] cmt_old_preg,
    input  logic          flush
);
    logic                  fl_empty;
    logic                  iss_fire;
    logic [CW-1:0]         fl_count;
    logic [NL-1:0][PW-1:0] spec_map;
    logic [NL-1:0][PW-1:0] cmt_map;
    logic [NL-1:0][PW-1:0] cmt_map_next;

    assign iss_ready = !fl_empty && !flush;
    assign iss_fire  = iss_valid && iss_ready;

    rename_map_table #(.NL(NL), .NP(NP)) u_map (
        .clk            (clk),
        .rst_n          (rst_n),
        .iss_fire       (iss_fire),
        .iss_dst        (iss_dst),
        .iss_new        (iss_new_preg),
        .look_a         (iss_src_a),
        .look_b         (iss_src_b),
        .cmt_valid      (cmt_valid),
        .cmt_dst        (cmt_dst),
        .cmt_new        (cmt_new_preg),
        .flush          (flush),
        .dst_prev       (iss_old_preg),
        .look_a_preg    (src_a_preg),
        .look_b_preg    (src_b_preg),
        .spec_map_o     (spec_map),
        .cmt_map_o      (cmt_map),
        .cmt_map_next_o (cmt_map_next)
    );

    rename_free_list #(.NL(NL), .NP(NP)) u_free (
        .clk         (clk),
        .rst_n       (rst_n),
        .pop         (iss_fire),
        .push        (cmt_valid),
        .push_preg   (cmt_old_preg),
        .rebuild     (flush),
        .rebuild_map (cmt_map_next),
        .head_preg   (iss_new_preg),
        .empty       (fl_empty),
        .count       (fl_count)
    );
endmodule

// File: rtl/reg_rename_chk.sv
module reg_rename_chk
    import rename_pkg::*;
#(
    parameter int unsigned NL = LOG_REGS_DEF,
    parameter int unsigned NP = PHYS_REGS_DEF,
    localparam int unsigned LW = idx_bits(NL),
    localparam int unsigned PW = idx_bits(NP),
    localparam int unsigned CW = $clog2(NP - NL + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  fire,
    input logic                  flush,
    input logic [LW-1:0]         dst,
    input logic [PW-1:0]         new_preg,
    input logic [PW-1:0]         old_preg,
    input logic [NL-1:0][PW-1:0] spec_map,
    input logic [NL-1:0][PW-1:0] cmt_map,
    input logic [CW-1:0]         fl_count
);
    AST_FRESH_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> (new_preg != old_preg));                                  // R2
    AST_ISSUE_UPDATES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (spec_map[$past(dst)] == $past(new_preg)));               // R2
    AST_NO_ISSUE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_count == '0) |-> !fire);                                       // R6
    AST_FREE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        fl_count <= CW'(NP - NL));                                         // R5
    AST_FLUSH_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (spec_map == cmt_map));                                  // R7
    AST_FLUSH_REFILLS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (fl_count == CW'(NP - NL)));                             // R8
endmodule

bind reg_rename reg_rename_chk #(.NL(NL), .NP(NP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (iss_fire),
    .flush    (flush),
    .dst      (iss_dst),
    .new_preg (iss_new_preg),
    .old_preg (iss_old_preg),
    .spec_map (spec_map),
    .cmt_map  (cmt_map),
    .fl_count (fl_count)
);

// File: tb/reg_rename_test.sv
module reg_rename_test;
    localparam int NL = 8;
    localparam int NP = 24;
    localparam int LW = 3;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          iss_valid = 1'b0, cmt_valid = 1'b0, flush = 1'b0;
    logic [LW-1:0] iss_dst = '0, iss_src_a = '0, iss_src_b = '0, cmt_dst = '0;
    logic [PW-1:0] cmt_new_preg = '0, cmt_old_preg = '0;
    logic          iss_ready;
    logic [PW-1:0] iss_new_preg, iss_old_preg, src_a_preg, src_b_preg;

    always #10 clk = ~clk;

    reg_rename uut (.*);

    int checks = 0, fails = 0;
    int mspec[NL], mcmt[NL];
    int fq[$];
    int inf_dst[$], inf_new[$], inf_old[$];
    bit finished = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic rebuild_model();
        fq.delete();
        for (int p = 0; p < NP; p++) begin
            bit hit = 0;
            for (int l = 0; l < NL; l++) if (mcmt[l] == p) hit = 1;
            if (!hit) fq.push_back(p);
        end
        inf_dst.delete(); inf_new.delete(); inf_old.delete();
    endtask

    task automatic step(input string tag, input bit iv, input int dst, input int sa,
                        input int sb, input bit cv, input bit fl);
        bit rdy, cve;
        int cd, cn, co, nw, od;
        @(negedge clk);
        cve = cv && (inf_dst.size() > 0);
        cd = cve ? inf_dst[0] : 0;
        cn = cve ? inf_new[0] : 0;
        co = cve ? inf_old[0] : 0;
        iss_valid = iv; iss_dst = LW'(dst); iss_src_a = LW'(sa); iss_src_b = LW'(sb);
        cmt_valid = cve; cmt_dst = LW'(cd); cmt_new_preg = PW'(cn); cmt_old_preg = PW'(co);
        flush = fl;
        #2;
        rdy = (fq.size() > 0) && !fl;
        chk(tag, "iss_ready", int'(iss_ready), int'(rdy));
        chk(tag, "src_a", int'(src_a_preg), mspec[sa]);
        chk(tag, "src_b", int'(src_b_preg), mspec[sb]);
        nw = 0; od = 0;
        if (iv && rdy) begin
            nw = fq[0];
            od = mspec[dst];
            chk(tag, "new preg", int'(iss_new_preg), nw);
            chk(tag, "old preg", int'(iss_old_preg), od);
        end
        @(posedge clk);
        #1;
        if (cve) begin
            mcmt[cd] = cn;
            fq.push_back(co);
            void'(inf_dst.pop_front()); void'(inf_new.pop_front()); void'(inf_old.pop_front());
        end
        if (fl) begin
            for (int l = 0; l < NL; l++) mspec[l] = mcmt[l];
            rebuild_model();
        end else if (iv && rdy) begin
            void'(fq.pop_front());
            mspec[dst] = nw;
            inf_dst.push_back(dst); inf_new.push_back(nw); inf_old.push_back(od);
        end
        iss_valid = 0; cmt_valid = 0; flush = 0;
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int l = 0; l < NL; l++) begin mspec[l] = l; mcmt[l] = l; end
        rebuild_model();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        chk("R1", "first free", int'(iss_new_preg), NL);
        chk("R1", "ready after reset", int'(iss_ready), 1);
        for (int i = 0; i < NL; i++) step("R1", 0, 0, i, NL - 1 - i, 0, 0);

        // drain the queue; sources equal to the destination read the old mapping
        for (int i = 0; i < NP - NL; i++)
            step((i % 3 == 0) ? "R2" : (i % 3 == 1) ? "R3" : "R4",
                 1, i % NL, i % NL, (i + 1) % NL, 0, 0);

        // R6: empty queue stalls issue and leaves the map alone
        step("R6", 1, 2, 2, 3, 0, 0);
        for (int i = 0; i < NL; i++) step("R6", 1, i, i, i, 0, 0);

        // R9: commits leave the speculative map unchanged
        for (int i = 0; i < 4; i++) step("R9", 0, 0, i, i + 4, 1, 0);
        // R5: freed registers come back in commit order
        for (int i = 0; i < 5; i++) step("R5", 1, 7 - i, i, 7 - i, 0, 0);

        // R7 / R8: flush restores map and rebuilds queue
        step("R7", 1, 1, 0, 1, 0, 1);
        for (int i = 0; i < NL; i++) step("R7", 0, 0, i, NL - 1 - i, 0, 0);
        for (int i = 0; i < NP - NL + 1; i++) step("R8", 1, (3 * i) % NL, i % NL, 5, 0, 0);

        // R10: commit and flush in the same cycle
        for (int i = 0; i < 4; i++) step("R10", 0, 0, i, i, 1, 0);
        for (int i = 0; i < 3; i++) step("R10", 1, i, 0, 1, 0, 0);
        step("R10", 1, 6, 0, 1, 1, 1);
        for (int i = 0; i < NL; i++) step("R10", 0, 0, i, NL - 1 - i, 0, 0);
        step("R10", 1, 4, 4, 0, 0, 0);

        // mixed pseudo-random traffic
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R3", lfsr[0] | lfsr[1], int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]),
                 lfsr[11] & ~lfsr[2], lfsr[15:12] == 4'd0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule